// File: doc/BRIEF.md
# Analog Watchdog Window Comparator for Buffered Conversion Results

This block watches the conversion results that a converter writes into a bank of ten data-buffer slots. Software loads a 10-bit upper bound and a 10-bit lower bound, and picks the slots to be watched. Whenever a result lands in a watched slot with a value above the upper bound or below the lower bound, the block latches a per-slot event flag. The flag stays set until software clears it.

Software reaches the block through a byte-wide register window of eight consecutive addresses, starting at base 0x28. Each 10-bit quantity is split into two bytes. A result-write port carries the slot number, the value and three mode bits: buffer, continuous and scan. Results are checked only while the converter runs either with both buffer and continuous set, or with scan set.

An interrupt request output is high whenever any event flag is set.

Top module: `awd_window_top`

## Requirements
- R1: After reset, the registers read as follows: 0x28 reads 0xFF and 0x29 reads 0x03, so the upper bound is 0x3FF. Every other address from 0x2A to 0x2F reads 0x00, and irq is low.
- R2: Writing 0x28 or 0x2A sets bits 9:2 of the upper or lower bound. Writing 0x29 or 0x2B sets bits 1:0 from data bits 1:0. The new value reads back on the next cycle.
- R3: Bits 7:2 of addresses 0x29, 0x2B, 0x2C and 0x2E always read 0 and ignore writes. Enable bits 9:8 sit in bits 1:0 of 0x2E, and enable bits 7:0 sit at 0x2F. Addresses outside 0x28 to 0x2F read 0.
- R4: A result that is strictly above the upper bound or strictly below the lower bound, written to an enabled slot while the mode qualifier holds, sets that slot's flag. The flag is visible one clock later: bits 9:8 in 0x2C bits 1:0, and bits 7:0 at 0x2D.
- R5: A result equal to either bound sets no flag.
- R6: A result written to a slot whose enable bit is 0 sets no flag.
- R7: A result sets no flag when its slot number is 10 or more, or when the mode qualifier (buffer AND continuous) OR scan is false.
- R8: Writing 0 to a flag bit through 0x2C or 0x2D clears that flag. Writing 1 leaves it unchanged.
- R9: A flag being set by hardware and cleared by software in the same cycle ends up set.
- R10: irq equals the OR of all ten flags.
- R11: Flags are sticky: a later in-window result to the same slot does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| res_valid | input | 1 | Result write strobe |
| res_slot | input | 4 | Destination slot number |
| res_value | input | 10 | Conversion result |
| mode_buf | input | 1 | Buffered mode active |
| mode_cont | input | 1 | Continuous mode active |
| mode_scan | input | 1 | Scan mode active |
| irq | output | 1 | OR of all event flags |

## Verification
The bench aims results exactly at each bound. A design that uses inclusive comparisons would flag these results, which the window should accept. It also writes to disabled slots, to slot numbers 10 through 15, and with each partial mode combination. A design that ignores the enable, the slot range or the mode qualifier would set stray flags in those cases.

The bench pairs a software clear with a hardware set on the same flag in the same cycle. A design that lets the clear win would drop the event. It writes reserved upper bits as 1s, which a design without masking would read back. A long random phase then mixes register writes, clears and results against the behavioural model, and compares on every clock.

// File: rtl/awd_pkg.sv
package awd_pkg;
  // Result and slot widths; the split fields derive from these
  parameter int unsigned RES_W   = 10;
  parameter int unsigned N_SLOTS = 10;
  localparam int unsigned SLOT_W = $clog2(N_SLOTS + 6);

  // Byte offsets within the register window (base must be 8-aligned)
  localparam logic [2:0] OFS_HI_BND_MSB = 3'd0;
  localparam logic [2:0] OFS_HI_BND_LSB = 3'd1;
  localparam logic [2:0] OFS_LO_BND_MSB = 3'd2;
  localparam logic [2:0] OFS_LO_BND_LSB = 3'd3;
  localparam logic [2:0] OFS_FLAG_UP    = 3'd4;
  localparam logic [2:0] OFS_FLAG_DN    = 3'd5;
  localparam logic [2:0] OFS_WATCH_UP   = 3'd6;
  localparam logic [2:0] OFS_WATCH_DN   = 3'd7;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int unsigned W     = RES_W,
  parameter int unsigned S     = N_SLOTS,
  parameter logic [7:0]  BASE  = 8'h28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [7:0]   addr,
  input  logic [7:0]   wdata,
  input  logic [S-1:0] flags,
  output logic [W-1:0] hi_bnd,
  output logic [W-1:0] lo_bnd,
  output logic [S-1:0] watch,
  output logic [S-1:0] clr_mask,
  output logic [7:0]   rdata
);
  localparam int unsigned BL = W - 8;  // bound bits held in the LSB byte
  localparam int unsigned SU = S - 8;  // slot bits held in the upper byte

  logic         in_win;
  logic [2:0]   ofs;
  logic         wr_hit;
  logic [W-1:0] hi_d, lo_d;
  logic [S-1:0] watch_d;

  assign in_win = (addr[7:3] == BASE[7:3]);
  assign ofs    = addr[2:0];
  assign wr_hit = wr && in_win;

  // Next-state for the software-owned fields
  always_comb begin
    hi_d    = hi_bnd;
    lo_d    = lo_bnd;
    watch_d = watch;
    case (ofs)
      OFS_HI_BND_MSB: hi_d[W-1:BL]    = wdata;
      OFS_HI_BND_LSB: hi_d[BL-1:0]    = wdata[BL-1:0];
      OFS_LO_BND_MSB: lo_d[W-1:BL]    = wdata;
      OFS_LO_BND_LSB: lo_d[BL-1:0]    = wdata[BL-1:0];
      OFS_WATCH_UP:   watch_d[S-1:8]  = wdata[SU-1:0];
      OFS_WATCH_DN:   watch_d[7:0]    = wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_bnd <= '1;
      lo_bnd <= '0;
      watch  <= '0;
    end else if (wr_hit) begin
      hi_bnd <= hi_d;
      lo_bnd <= lo_d;
      watch  <= watch_d;
    end
  end

  // Write-zero-to-clear decode for the flag bytes
  always_comb begin
    clr_mask = '0;
    if (wr_hit && ofs == OFS_FLAG_UP) clr_mask[S-1:8] = ~wdata[SU-1:0];
    if (wr_hit && ofs == OFS_FLAG_DN) clr_mask[7:0]   = ~wdata;
  end

  always_comb begin
    rdata = '0;
    if (in_win) begin
      case (ofs)
        OFS_HI_BND_MSB: rdata = hi_bnd[W-1:BL];
        OFS_HI_BND_LSB: rdata = {{(8-BL){1'b0}}, hi_bnd[BL-1:0]};
        OFS_LO_BND_MSB: rdata = lo_bnd[W-1:BL];
        OFS_LO_BND_LSB: rdata = {{(8-BL){1'b0}}, lo_bnd[BL-1:0]};
        OFS_FLAG_UP:    rdata = {{(8-SU){1'b0}}, flags[S-1:8]};
        OFS_FLAG_DN:    rdata = flags[7:0];
        OFS_WATCH_UP:   rdata = {{(8-SU){1'b0}}, watch[S-1:8]};
        default:        rdata = watch[7:0];
      endcase
    end
  end

  // R3: reserved bits of the narrow bytes never read as 1
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && (ofs == OFS_HI_BND_LSB || ofs == OFS_LO_BND_LSB ||
                ofs == OFS_FLAG_UP || ofs == OFS_WATCH_UP)) |-> (rdata[7:2] == 6'd0));
endmodule

// File: rtl/awd_compare.sv
module awd_compare
  import awd_pkg::*;
#(
  parameter int unsigned W  = RES_W,
  parameter int unsigned S  = N_SLOTS,
  parameter int unsigned SW = SLOT_W
) (
  input  logic [W-1:0]  hi_bnd,
  input  logic [W-1:0]  lo_bnd,
  input  logic [S-1:0]  watch,
  input  logic          valid,
  input  logic [SW-1:0] slot,
  input  logic [W-1:0]  value,
  input  logic          m_buf,
  input  logic          m_cont,
  input  logic          m_scan,
  output logic [S-1:0]  set_vec
);
  logic mode_ok;
  logic outside;

  assign mode_ok = (m_buf && m_cont) || m_scan;
  assign outside = (value > hi_bnd) || (value < lo_bnd);

  for (genvar g = 0; g < S; g++) begin : g_slot
    assign set_vec[g] = valid && mode_ok && outside && watch[g] &&
                        (slot == SW'(g));
  end
endmodule

// File: rtl/awd_status.sv
module awd_status #(
  parameter int unsigned S = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [S-1:0] set_vec,
  input  logic [S-1:0] clr_mask,
  output logic [S-1:0] flags
);
  logic [S-1:0] flags_d;
  logic         upd;

  assign upd     = (|set_vec) || (|clr_mask);
  assign flags_d = (flags & ~clr_mask) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= flags_d;
  end

  // R4/R9: every requested set lands, whatever clear comes with it
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  // R11: a set flag with no clear request stays set
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~clr_mask)) |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));
  // R8: a cleared flag with no set request drops
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_vec)) |=> ((flags & $past(clr_mask & ~set_vec)) == '0));
endmodule

// File: rtl/awd_window_top.sv
module awd_window_top
  import awd_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              res_valid,
  input  logic [SLOT_W-1:0] res_slot,
  input  logic [RES_W-1:0]  res_value,
  input  logic              mode_buf,
  input  logic              mode_cont,
  input  logic              mode_scan,
  output logic              irq
);
  logic [RES_W-1:0]   hi_bnd, lo_bnd;
  logic [N_SLOTS-1:0] watch, clr_mask, set_vec, flags;

  awd_regfile #(.W(RES_W), .S(N_SLOTS), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flags), .hi_bnd(hi_bnd), .lo_bnd(lo_bnd), .watch(watch),
    .clr_mask(clr_mask), .rdata(reg_rdata)
  );

  awd_compare #(.W(RES_W), .S(N_SLOTS), .SW(SLOT_W)) u_cmp (
    .hi_bnd(hi_bnd), .lo_bnd(lo_bnd), .watch(watch), .valid(res_valid),
    .slot(res_slot), .value(res_value), .m_buf(mode_buf), .m_cont(mode_cont),
    .m_scan(mode_scan), .set_vec(set_vec)
  );

  awd_status #(.S(N_SLOTS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_mask(clr_mask), .flags(flags)
  );

  assign irq = |flags;

  // R7: unqualified or out-of-range results raise nothing
  assert_unqualified_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid || (res_slot >= SLOT_W'(N_SLOTS)) ||
     !((mode_buf && mode_cont) || mode_scan)) |=> ((flags & ~$past(flags)) == '0));
  // R6: a newly raised flag belongs to an enabled slot
  assert_only_watched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(watch)) == '0));
  // R5: results inside or on the bounds raise nothing
  assert_inclusive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_value <= hi_bnd && res_value >= lo_bnd) |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: tb/awd_window_top_tb.sv
`timescale 1ns/1ps
module awd_window_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       res_valid;
  logic [3:0] res_slot;
  logic [9:0] res_value;
  logic       mode_buf, mode_cont, mode_scan;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural model state
  int unsigned m_hi, m_lo, m_en, m_fl;

  always #2 clk = ~clk;

  awd_window_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid),
    .res_slot(res_slot), .res_value(res_value), .mode_buf(mode_buf),
    .mode_cont(mode_cont), .mode_scan(mode_scan), .irq(irq)
  );

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h28: return 8'((m_hi >> 2) & 8'hFF);
      8'h29: return 8'(m_hi & 3);
      8'h2A: return 8'((m_lo >> 2) & 8'hFF);
      8'h2B: return 8'(m_lo & 3);
      8'h2C: return 8'((m_fl >> 8) & 3);
      8'h2D: return 8'(m_fl & 8'hFF);
      8'h2E: return 8'((m_en >> 8) & 3);
      8'h2F: return 8'(m_en & 8'hFF);
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [7:0] er;
    logic       ei;
    er = m_read(reg_addr);
    ei = (m_fl != 0);
    n_cmp++;
    if (reg_rdata !== er || irq !== ei) begin
      n_bad++;
      $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b",
               tag, reg_addr, reg_rdata, er, irq, ei);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare next negedge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d,
                     input logic rv, input logic [3:0] s, input logic [9:0] v,
                     input logic b, input logic c, input logic sc, input string tag);
    int unsigned setm, clrm;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    res_valid = rv; res_slot = s; res_value = v;
    mode_buf = b; mode_cont = c; mode_scan = sc;
    @(posedge clk);
    setm = 0; clrm = 0;
    if (rv && s < 10 && ((b && c) || sc) && ((m_en >> s) & 1) != 0 &&
        (int'(v) > int'(m_hi) || int'(v) < int'(m_lo)))
      setm = 1 << s;
    if (w && a == 8'h2C) clrm = ((~int'(d)) & 3) << 8;
    if (w && a == 8'h2D) clrm = (~int'(d)) & 8'hFF;
    m_fl = (m_fl & ~clrm) | setm;
    if (w) begin
      case (a)
        8'h28: m_hi = (m_hi & 3) | (int'(d) << 2);
        8'h29: m_hi = (m_hi & 10'h3FC) | (int'(d) & 3);
        8'h2A: m_lo = (m_lo & 3) | (int'(d) << 2);
        8'h2B: m_lo = (m_lo & 10'h3FC) | (int'(d) & 3);
        8'h2E: m_en = (m_en & 8'hFF) | ((int'(d) & 3) << 8);
        8'h2F: m_en = (m_en & 10'h300) | int'(d);
        default: ;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(0, a, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic res(input logic [3:0] s, input logic [9:0] v, input logic b,
                     input logic c, input logic sc, input logic [7:0] a, input string tag);
    cyc(0, a, 0, 1, s, v, b, c, sc, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_hi = 10'h3FF; m_lo = 0; m_en = 0; m_fl = 0;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    res_valid = 0; res_slot = 0; res_value = 0;
    mode_buf = 0; mode_cont = 0; mode_scan = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 8'h28; a <= 8'h2F; a++) rd(8'(a), "R1");
    // R2 bound writes, R3 reserved bits and enables
    wr(8'h28, 8'hB1, "R2"); wr(8'h29, 8'hFD, "R3");
    rd(8'h28, "R2"); rd(8'h29, "R3");
    wr(8'h2A, 8'h10, "R2"); wr(8'h2B, 8'hFC, "R3");
    rd(8'h2A, "R2"); rd(8'h2B, "R3");
    wr(8'h2E, 8'hFF, "R3"); wr(8'h2F, 8'h5A, "R3");
    rd(8'h2E, "R3"); rd(8'h2F, "R3"); rd(8'h30, "R3"); rd(8'h27, "R3");
    wr(8'h2C, 8'hFF, "R3"); rd(8'h2C, "R3");
    // bounds now hi=0x2C5 lo=0x040, watched slots 1,3,4,6,8,9
    res(1, 10'h3FF, 0, 0, 1, 8'h2D, "R4");
    res(3, 10'h03F, 0, 0, 1, 8'h2D, "R4_R10");
    res(4, 10'h2C5, 0, 0, 1, 8'h2D, "R5");
    res(6, 10'h040, 0, 0, 1, 8'h2D, "R5");
    res(0, 10'h3FF, 1, 1, 1, 8'h2D, "R6");
    res(2, 10'h000, 1, 1, 0, 8'h2D, "R6");
    res(9, 10'h3FF, 1, 0, 0, 8'h2C, "R7");
    res(9, 10'h3FF, 0, 1, 0, 8'h2C, "R7");
    res(12, 10'h3FF, 1, 1, 1, 8'h2C, "R7");
    res(15, 10'h000, 1, 1, 1, 8'h2D, "R7");
    res(9, 10'h3FF, 1, 1, 0, 8'h2C, "R4");
    res(1, 10'h100, 0, 0, 1, 8'h2D, "R11");
    // R8 clears
    wr(8'h2D, 8'hFD, "R8"); rd(8'h2D, "R8");
    wr(8'h2C, 8'hFE, "R8"); wr(8'h2C, 8'h00, "R8"); rd(8'h2C, "R8");
    // R9 set beats clear in the same cycle
    cyc(1, 8'h2D, 8'h00, 1, 3, 10'h001, 0, 0, 1, "R9");
    rd(8'h2D, "R9");
    wr(8'h2D, 8'h00, "R10"); rd(8'h2D, "R10");
    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = 8'(8'h26 + ($urandom % 12));
      cyc(($urandom % 4) == 0, a, 8'($urandom), ($urandom % 2) == 1,
          4'($urandom), 10'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), "R4_R8_R9_rand");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule